// File: doc/BRIEF.md
# Adaptive Output Port Selector

This block sits in the routing engine of a seven-port mesh router. For a packet header, the routing function offers up to two candidate output ports. The selector compares congestion figures for those two ports, picks one, and registers the choice. Each port supplies three figures: bandwidth slots already reserved on its link, message ID slots already in use, and how many entries wait in the input FIFO of the neighbour downstream. The ID-slot count of a port equals the number of wormhole messages currently interleaved on that link.

The policy input chooses between two rankings. The first ranks by reserved bandwidth and breaks a tie on reserved ID slots. The second ranks on downstream queue length alone. The decision is taken only when a header flit is presented, and it stays on the output for the rest of the message. A one-cycle valid pulse marks each new decision.

Top module: `adaptive_port_sel`

## Requirements
- R1: With policy_i=0 and both candidates usable, the candidate whose port has fewer reserved bandwidth slots is chosen.
- R2: With policy_i=0, if both candidates have the same reserved bandwidth count, the one with fewer reserved ID slots is chosen.
- R3: With policy_i=1, only the downstream queue counts are compared. The candidate with the shorter queue is chosen, and the bandwidth and ID counts have no effect.
- R4: If every compared count is equal, the candidate with the lower port code is chosen.
- R5: A candidate is usable only when its valid bit is 1 and its code lies in 1..7. If exactly one candidate is usable, it is chosen whatever its counts are.
- R6: The clock edge that samples hdr_valid_i=1 with at least one usable candidate loads the choice into sel_port_o and raises sel_valid_o for exactly that following cycle.
- R7: sel_port_o keeps its value when hdr_valid_i=0, even if the counts change. It also keeps its value when a header arrives with no usable candidate, and in that case sel_valid_o stays 0.
- R8: After reset, sel_port_o is 0 and sel_valid_o is 0.
- R9: Port codes are East=1, North1=2, West=3, South1=4, North2=5, South2=6, Local=7. The 4-bit unsigned counts of port code p occupy bits [(p-1)*4 +: 4] of each metric bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | A header flit is presented this cycle |
| policy_i | input | 1 | 0: bandwidth then ID ranking, 1: queue-length ranking |
| cand_a_i | input | 3 | First candidate port code |
| cand_a_vld_i | input | 1 | First candidate offered |
| cand_b_i | input | 3 | Second candidate port code |
| cand_b_vld_i | input | 1 | Second candidate offered |
| bw_rsv_i | input | 28 | Reserved bandwidth slots, 4 bits per port |
| id_rsv_i | input | 28 | Reserved message ID slots, 4 bits per port |
| q_len_i | input | 28 | Downstream queue occupancy, 4 bits per port |
| sel_port_o | output | 3 | Registered chosen port code |
| sel_valid_o | output | 1 | One-cycle pulse for a new choice |

## Verification
The bench builds the block with its default parameters: seven ports, 4-bit counts and 3-bit codes. With these values every port code, the invalid code 0 and the full count range 0..15 can be reached. That covers saturated ties at 15 and a bandwidth difference that points the other way from the queue difference. A pseudo-random sweep over all candidate pairs and both policies is compared each clock against a behavioural model of the rankings.

// File: rtl/aps_pkg.sv
package aps_pkg;
  typedef enum logic {
    POL_BW_ID = 1'b0,
    POL_QUEUE = 1'b1
  } policy_e;
endpackage

// File: rtl/aps_metric_fetch.sv
module aps_metric_fetch #(
  parameter int NP = 7,
  parameter int MW = 4,
  parameter int PW = 3
) (
  input  logic [PW-1:0]    port_i,
  input  logic [NP*MW-1:0] bw_all_i,
  input  logic [NP*MW-1:0] id_all_i,
  input  logic [NP*MW-1:0] q_all_i,
  output logic [MW-1:0]    bw_o,
  output logic [MW-1:0]    id_o,
  output logic [MW-1:0]    q_o
);
  // code p maps to slice p-1; code 0 yields zeros
  always_comb begin
    bw_o = '0;
    id_o = '0;
    q_o  = '0;
    for (int i = 0; i < NP; i++) begin
      if (port_i == PW'(i + 1)) begin
        bw_o = bw_all_i[i*MW +: MW];
        id_o = id_all_i[i*MW +: MW];
        q_o  = q_all_i[i*MW +: MW];
      end
    end
  end
endmodule

// File: rtl/aps_rank.sv
module aps_rank
  import aps_pkg::*;
#(
  parameter int MW = 4,
  parameter int PW = 3
) (
  input  policy_e       policy_i,
  input  logic          a_ok_i,
  input  logic [PW-1:0] a_port_i,
  input  logic [MW-1:0] a_bw_i,
  input  logic [MW-1:0] a_id_i,
  input  logic [MW-1:0] a_q_i,
  input  logic          b_ok_i,
  input  logic [PW-1:0] b_port_i,
  input  logic [MW-1:0] b_bw_i,
  input  logic [MW-1:0] b_id_i,
  input  logic [MW-1:0] b_q_i,
  output logic          pick_ok_o,
  output logic [PW-1:0] pick_port_o
);
  localparam int KW = 2 * MW;

  logic [KW-1:0] key_a, key_b;
  logic          a_wins;

  always_comb begin
    if (policy_i == POL_BW_ID) begin
      key_a = {a_bw_i, a_id_i};
      key_b = {b_bw_i, b_id_i};
    end else begin
      key_a = {{MW{1'b0}}, a_q_i};
      key_b = {{MW{1'b0}}, b_q_i};
    end
    a_wins = (key_a < key_b) || ((key_a == key_b) && (a_port_i <= b_port_i));
  end

  always_comb begin
    pick_ok_o = a_ok_i | b_ok_i;
    if (a_ok_i && b_ok_i) pick_port_o = a_wins ? a_port_i : b_port_i;
    else if (a_ok_i)      pick_port_o = a_port_i;
    else if (b_ok_i)      pick_port_o = b_port_i;
    else                  pick_port_o = '0;
  end
endmodule

// File: rtl/adaptive_port_sel.sv
module adaptive_port_sel
  import aps_pkg::*;
#(
  parameter int NP = 7,
  parameter int MW = 4,
  parameter int PW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_valid_i,
  input  logic             policy_i,
  input  logic [PW-1:0]    cand_a_i,
  input  logic             cand_a_vld_i,
  input  logic [PW-1:0]    cand_b_i,
  input  logic             cand_b_vld_i,
  input  logic [NP*MW-1:0] bw_rsv_i,
  input  logic [NP*MW-1:0] id_rsv_i,
  input  logic [NP*MW-1:0] q_len_i,
  output logic [PW-1:0]    sel_port_o,
  output logic             sel_valid_o
);
  localparam int NC = 2;

  policy_e       pol;
  logic [PW-1:0] cand [NC];
  logic          vld  [NC];
  logic          ok   [NC];
  logic [MW-1:0] bw_c [NC];
  logic [MW-1:0] id_c [NC];
  logic [MW-1:0] q_c  [NC];
  logic          pick_ok;
  logic [PW-1:0] pick_port;

  assign pol     = policy_e'(policy_i);
  assign cand[0] = cand_a_i;
  assign cand[1] = cand_b_i;
  assign vld[0]  = cand_a_vld_i;
  assign vld[1]  = cand_b_vld_i;

  for (genvar k = 0; k < NC; k++) begin : g_cand
    assign ok[k] = vld[k] && (cand[k] != '0) && (cand[k] <= PW'(NP));
    aps_metric_fetch #(.NP(NP), .MW(MW), .PW(PW)) u_fetch (
      .port_i  (cand[k]),
      .bw_all_i(bw_rsv_i),
      .id_all_i(id_rsv_i),
      .q_all_i (q_len_i),
      .bw_o    (bw_c[k]),
      .id_o    (id_c[k]),
      .q_o     (q_c[k])
    );
  end

  aps_rank #(.MW(MW), .PW(PW)) u_rank (
    .policy_i   (pol),
    .a_ok_i     (ok[0]),
    .a_port_i   (cand[0]),
    .a_bw_i     (bw_c[0]),
    .a_id_i     (id_c[0]),
    .a_q_i      (q_c[0]),
    .b_ok_i     (ok[1]),
    .b_port_i   (cand[1]),
    .b_bw_i     (bw_c[1]),
    .b_id_i     (id_c[1]),
    .b_q_i      (q_c[1]),
    .pick_ok_o  (pick_ok),
    .pick_port_o(pick_port)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_port_o  <= '0;
      sel_valid_o <= 1'b0;
    end else begin
      sel_valid_o <= hdr_valid_i && pick_ok;
      if (hdr_valid_i && pick_ok) sel_port_o <= pick_port;
    end
  end

  a_r1_bw_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && ok[0] && ok[1] && pol == POL_BW_ID && bw_c[0] < bw_c[1])
    |=> sel_port_o == $past(cand_a_i));

  a_r2_id_tiebreak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && ok[0] && ok[1] && pol == POL_BW_ID && bw_c[0] == bw_c[1] && id_c[0] > id_c[1])
    |=> sel_port_o == $past(cand_b_i));

  a_r3_queue_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && ok[0] && ok[1] && pol == POL_QUEUE && q_c[1] < q_c[0])
    |=> sel_port_o == $past(cand_b_i));

  a_r6_valid_needs_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> $past(hdr_valid_i));

  a_r7_hold_no_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_valid_i |=> $stable(sel_port_o));
endmodule

// File: tb/sim_adaptive_port_sel.sv
`timescale 1ns/1ps
module sim_adaptive_port_sel;
  localparam int NP = 7;
  localparam int MW = 4;
  localparam int PW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hdr = 1'b0;
  logic             pol = 1'b0;
  logic [PW-1:0]    ca = '0, cb = '0;
  logic             va = 1'b0, vb = 1'b0;
  logic [NP*MW-1:0] bw_v = '0, id_v = '0, q_v = '0;
  logic [PW-1:0]    sel_port;
  logic             sel_valid;

  int m_bw [1:7];
  int m_id [1:7];
  int m_q  [1:7];
  int exp_port = 0;
  int exp_vld  = 0;
  int total = 0;
  int bad   = 0;
  int seed  = 12345;

  always #2.5 clk = ~clk;

  adaptive_port_sel #(.NP(NP), .MW(MW), .PW(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(hdr), .policy_i(pol),
    .cand_a_i(ca), .cand_a_vld_i(va), .cand_b_i(cb), .cand_b_vld_i(vb),
    .bw_rsv_i(bw_v), .id_rsv_i(id_v), .q_len_i(q_v),
    .sel_port_o(sel_port), .sel_valid_o(sel_valid)
  );

  task automatic setm(input int p, input int b, input int i, input int q);
    m_bw[p] = b; m_id[p] = i; m_q[p] = q;
    bw_v[(p-1)*MW +: MW] = b[MW-1:0];
    id_v[(p-1)*MW +: MW] = i[MW-1:0];
    q_v[(p-1)*MW +: MW]  = q[MW-1:0];
  endtask

  function automatic int model_pick(int a, int a_v, int b, int b_v, int p);
    bit ua = (a_v != 0) && a >= 1 && a <= 7;
    bit ub = (b_v != 0) && b >= 1 && b <= 7;
    int ka, kb;
    if (!ua && !ub) return 0;
    if (!ub) return a;
    if (!ua) return b;
    ka = (p == 0) ? m_bw[a] * 16 + m_id[a] : m_q[a];
    kb = (p == 0) ? m_bw[b] * 16 + m_id[b] : m_q[b];
    if (ka < kb) return a;
    if (kb < ka) return b;
    return (a < b) ? a : b;
  endfunction

  task automatic check(input string tag);
    total++;
    if (sel_port !== PW'(exp_port) || sel_valid !== exp_vld[0]) begin
      bad++;
      $display("FAIL %s: port=%0d valid=%0d expected port=%0d valid=%0d",
               tag, sel_port, sel_valid, exp_port, exp_vld);
    end
  endtask

  // called at a negedge: drive, model, then check at the next negedge
  task automatic step(input int h, input int a, input int a_v, input int b,
                      input int b_v, input int p, input string tag);
    int pk;
    hdr = h[0]; ca = a[PW-1:0]; va = a_v[0]; cb = b[PW-1:0]; vb = b_v[0]; pol = p[0];
    pk = model_pick(a, a_v, b, b_v, p);
    if (h != 0 && pk != 0) begin exp_port = pk; exp_vld = 1; end
    else exp_vld = 0;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    for (int p = 1; p <= 7; p++) setm(p, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    check("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release");

    setm(1, 5, 0, 0); setm(3, 2, 9, 0);
    step(1, 1, 1, 3, 1, 0, "R1 fewer bw wins");
    step(0, 1, 1, 1, 1, 0, "R6 valid one cycle");
    setm(3, 14, 0, 0);
    step(0, 1, 1, 3, 1, 0, "R7 hold on metric change");

    setm(2, 4, 6, 0); setm(5, 4, 1, 0);
    step(1, 2, 1, 5, 1, 0, "R2 id tiebreak");
    setm(2, 4, 1, 0); setm(5, 4, 6, 0);
    step(1, 2, 1, 5, 1, 0, "R2 id tiebreak reversed");

    setm(6, 0, 0, 9); setm(7, 15, 15, 3);
    step(1, 6, 1, 7, 1, 1, "R3 queue wins over bw");
    step(1, 6, 1, 7, 1, 0, "R3 same pair bw policy");

    setm(4, 7, 7, 7); setm(7, 7, 7, 7);
    step(1, 7, 1, 4, 1, 0, "R4 tie lower code");
    step(1, 7, 1, 4, 1, 1, "R4 tie lower code queue");
    setm(1, 15, 15, 15); setm(2, 15, 15, 15);
    step(1, 2, 1, 1, 1, 0, "R4 saturated tie");

    step(1, 1, 0, 6, 1, 0, "R5 only b offered");
    step(1, 0, 1, 1, 1, 0, "R5 code 0 unusable");
    step(1, 4, 1, 6, 0, 1, "R5 only a offered");

    step(1, 3, 0, 5, 0, 0, "R7 header no candidate");
    step(1, 0, 1, 0, 1, 1, "R7 header code 0 both");

    setm(7, 0, 0, 0); setm(1, 15, 0, 0);
    step(1, 1, 1, 7, 1, 0, "R9 local slice");

    for (int n = 0; n < 300; n++) begin
      int a, b;
      for (int p = 1; p <= 7; p++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        setm(p, (seed >> 4) & 3, (seed >> 8) & 15, (seed >> 12) & 3);
      end
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      a = (seed >> 3) & 7; b = (seed >> 7) & 7;
      step((seed >> 11) & 1, a, ((seed >> 13) & 7) != 0, b,
           ((seed >> 16) & 7) != 0, (seed >> 19) & 1, "R9 sweep");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule